// File: doc/BRIEF.md
# Interval-Based Redundant-Execution Mode Controller

This block decides, one interval at a time, whether a redundant-stream execution mode should run. It watches the retirement stream of a core. Each cycle it receives how many instructions retired, how many of those were flagged by a removal predictor as having no effect, and an estimate of cycles saved. Intervals are fixed-length windows of retired instructions. At the close of each window, a benefit metric collected over that window is compared with a threshold. The result sets the mode enable for the next window.

A build-time choice picks the metric. The first option is the count of flagged instructions, tested against a percentage of the interval length without a divider. The second is the sum of cycles saved, tested against an absolute cycle threshold. A saturating confidence counter can require several qualifying intervals in a row before the mode turns on. Any interval that misses the threshold turns the mode off at once.

Top module: `slip_mode_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mode_en` is 0, and the interval position starts at zero.
- R2: An interval closes in the cycle where the running count of retired instructions reaches `INTERVAL_LEN`. That cycle is the boundary cycle.
- R3: When the group retiring in a boundary cycle takes the count past `INTERVAL_LEN`, the surplus instructions count toward the next interval.
- R4: In count mode, the per-cycle flagged count is clipped to the retire count. In a boundary cycle, flagged instructions go to the closing interval first, up to the number of slots it had left. The rest go to the next interval.
- R5: In count mode, an interval qualifies only if `flagged * PCT_DEN > PCT_NUM * INTERVAL_LEN`, a strict comparison. With 30/100 and length 20, 6 flagged instructions do not qualify and 7 do.
- R6: In cycles mode, the metric is the sum of `saved_cyc` over every cycle of the interval, including its boundary cycle. The interval qualifies only if that sum is strictly greater than `CYC_THRESH`.
- R7: Each qualifying interval raises a confidence count, which saturates at `CONF_N`. The enable for the next interval is 1 exactly when the count equals `CONF_N`. With `CONF_N`=2, two qualifying intervals in a row are needed.
- R8: An interval that does not qualify clears the confidence count to 0 and sets `mode_en` to 0 for the next interval.
- R9: `mode_en` is registered. It changes only at the clock edge that ends a boundary cycle, so it is visible from the following cycle.
- R10: In cycles mode, the accumulator saturates at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_cnt | input | $clog2(RET_W+1) | Instructions retired this cycle, 0 to RET_W |
| flag_cnt | input | $clog2(RET_W+1) | Retired instructions this cycle flagged as removable |
| saved_cyc | input | CYC_W | Cycles-saved increment for this cycle |
| mode_en | output | 1 | Registered redundant-mode enable for the current interval |

## Verification
The bench drives two small instances with a shared stimulus: one in count mode with a confidence depth of 2, and one in cycles mode with a narrow saturating accumulator. It runs a sweep of retire-group sizes from 0 to 4, so that boundaries land in the middle of groups. It also sends flagged counts larger than the retire count, and a design without clipping or surplus carry would shift every later boundary and flip the enable in the wrong cycle. Directed intervals sit exactly on the 30% line (6 of 20 flagged) and the cycle threshold (50 against 51), where a non-strict compare would turn the mode on. A single qualifying interval exposes a confidence counter that does not wait for N. A run of idle cycles that each save 15 cycles exposes an accumulator that wraps, because it would fall below the threshold and leave the mode off.

// File: rtl/slip_mode_pkg.sv
package slip_mode_pkg;
  // Which benefit metric the controller accumulates per interval.
  typedef enum logic {
    MET_COUNT  = 1'b0,   // flagged-instruction count vs percentage of interval
    MET_CYCLES = 1'b1    // cycles-saved sum vs absolute threshold
  } metric_e;
endpackage

// File: rtl/slip_interval_cnt.sv
// Tracks position inside the current interval and detects the boundary cycle.
module slip_interval_cnt #(
  parameter int unsigned LEN  = 4096,
  parameter int unsigned RCW  = 3,
  parameter int unsigned POSW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RCW-1:0]  retire_cnt,
  output logic            boundary,
  output logic [RCW-1:0]  slots_old,
  output logic [POSW-1:0] pos
);
  localparam int unsigned SW = POSW + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum       = SW'(pos) + SW'(retire_cnt);
    boundary  = (sum >= SW'(LEN));
    // slots of this group that still belong to the closing interval
    slots_old = boundary ? RCW'(SW'(LEN) - SW'(pos)) : retire_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)           pos <= '0;
    else if (boundary) pos <= POSW'(sum - SW'(LEN));
    else               pos <= POSW'(sum);
  end
endmodule

// File: rtl/slip_metric_acc.sv
// Accumulates the per-interval benefit metric; the variant is chosen by METRIC.
module slip_metric_acc
  import slip_mode_pkg::*;
#(
  parameter metric_e     METRIC = MET_COUNT,
  parameter int unsigned RCW    = 3,
  parameter int unsigned CYCW   = 8,
  parameter int unsigned MW     = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            boundary,
  input  logic [RCW-1:0]  retire_cnt,
  input  logic [RCW-1:0]  slots_old,
  input  logic [RCW-1:0]  flag_cnt,
  input  logic [CYCW-1:0] saved_cyc,
  output logic [MW-1:0]   total
);
  logic [MW-1:0] acc_q;

  generate
    if (METRIC == MET_COUNT) begin : g_count
      logic [RCW-1:0] flag_clip;
      logic [RCW-1:0] part_old;
      logic [RCW-1:0] part_new;
      logic           unused_cyc;

      assign unused_cyc = ^saved_cyc;

      always_comb begin
        flag_clip = (flag_cnt > retire_cnt) ? retire_cnt : flag_cnt;
        part_old  = (flag_clip > slots_old) ? slots_old : flag_clip;
        part_new  = flag_clip - part_old;
        total     = acc_q + MW'(part_old);
      end

      always_ff @(posedge clk) begin
        if (rst)           acc_q <= '0;
        else if (boundary) acc_q <= MW'(part_new);
        else               acc_q <= total;
      end
    end else begin : g_cycles
      logic [MW:0] sum_w;
      logic        unused_cnt;

      assign unused_cnt = ^{retire_cnt, slots_old, flag_cnt};

      always_comb begin
        sum_w = {1'b0, acc_q} + (MW+1)'(saved_cyc);
        total = sum_w[MW] ? {MW{1'b1}} : sum_w[MW-1:0];
      end

      always_ff @(posedge clk) begin
        if (rst)           acc_q <= '0;
        else if (boundary) acc_q <= '0;
        else               acc_q <= total;
      end
    end
  endgenerate
endmodule

// File: rtl/slip_mode_decide.sv
// Threshold test at the boundary, confidence counting and the registered enable.
module slip_mode_decide
  import slip_mode_pkg::*;
#(
  parameter metric_e     METRIC     = MET_COUNT,
  parameter int unsigned LEN        = 4096,
  parameter int unsigned PCT_NUM    = 30,
  parameter int unsigned PCT_DEN    = 100,
  parameter int unsigned CYC_THRESH = 1000,
  parameter int unsigned CONF_N     = 1,
  parameter int unsigned MW         = 13,
  parameter int unsigned CFW        = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           boundary,
  input  logic [MW-1:0]  total,
  output logic           qualify,
  output logic [CFW-1:0] conf,
  output logic           mode_en
);
  localparam logic [63:0] PCT_RHS = 64'(PCT_NUM) * 64'(LEN);

  logic [CFW-1:0] conf_inc;

  generate
    if (METRIC == MET_COUNT) begin : g_pct
      logic [63:0] lhs;
      always_comb begin
        lhs     = 64'(total) * 64'(PCT_DEN);
        qualify = (lhs > PCT_RHS);
      end
    end else begin : g_abs
      always_comb qualify = (64'(total) > 64'(CYC_THRESH));
    end
  endgenerate

  always_comb conf_inc = (conf == CFW'(CONF_N)) ? conf : conf + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      conf    <= '0;
      mode_en <= 1'b0;
    end else if (boundary) begin
      if (qualify) begin
        conf    <= conf_inc;
        mode_en <= (conf_inc == CFW'(CONF_N));
      end else begin
        conf    <= '0;
        mode_en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slip_mode_ctrl.sv
// Top: interval counter, metric accumulator and decision stage.
module slip_mode_ctrl
  import slip_mode_pkg::*;
#(
  parameter int unsigned INTERVAL_LEN = 4096,
  parameter int unsigned RET_W        = 4,
  parameter int unsigned PCT_NUM      = 30,
  parameter int unsigned PCT_DEN      = 100,
  parameter metric_e     METRIC       = MET_COUNT,
  parameter int unsigned CYC_W        = 8,
  parameter int unsigned CYC_ACC_W    = 20,
  parameter int unsigned CYC_THRESH   = 1000,
  parameter int unsigned CONF_N       = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(RET_W+1)-1:0]   retire_cnt,
  input  logic [$clog2(RET_W+1)-1:0]   flag_cnt,
  input  logic [CYC_W-1:0]             saved_cyc,
  output logic                         mode_en
);
  localparam int unsigned RCW  = $clog2(RET_W + 1);
  localparam int unsigned POSW = $clog2(INTERVAL_LEN);
  localparam int unsigned CNTW = $clog2(INTERVAL_LEN + 1);
  localparam int unsigned MW   = (METRIC == MET_COUNT) ? CNTW : CYC_ACC_W;
  localparam int unsigned CFW  = $clog2(CONF_N + 1);

  logic            boundary;
  logic [RCW-1:0]  slots_old;
  logic [POSW-1:0] pos;
  logic [MW-1:0]   total;
  logic            qualify;
  logic [CFW-1:0]  conf;

  slip_interval_cnt #(
    .LEN (INTERVAL_LEN),
    .RCW (RCW),
    .POSW(POSW)
  ) u_ivl (
    .clk       (clk),
    .rst       (rst),
    .retire_cnt(retire_cnt),
    .boundary  (boundary),
    .slots_old (slots_old),
    .pos       (pos)
  );

  slip_metric_acc #(
    .METRIC(METRIC),
    .RCW   (RCW),
    .CYCW  (CYC_W),
    .MW    (MW)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .boundary  (boundary),
    .retire_cnt(retire_cnt),
    .slots_old (slots_old),
    .flag_cnt  (flag_cnt),
    .saved_cyc (saved_cyc),
    .total     (total)
  );

  slip_mode_decide #(
    .METRIC    (METRIC),
    .LEN       (INTERVAL_LEN),
    .PCT_NUM   (PCT_NUM),
    .PCT_DEN   (PCT_DEN),
    .CYC_THRESH(CYC_THRESH),
    .CONF_N    (CONF_N),
    .MW        (MW),
    .CFW       (CFW)
  ) u_dec (
    .clk     (clk),
    .rst     (rst),
    .boundary(boundary),
    .total   (total),
    .qualify (qualify),
    .conf    (conf),
    .mode_en (mode_en)
  );
endmodule

// File: rtl/slip_mode_ctrl_chk.sv
// Property checker attached to every slip_mode_ctrl instance.
module slip_mode_ctrl_chk #(
  parameter int unsigned LEN    = 4096,
  parameter int unsigned CONF_N = 1,
  parameter int unsigned RCW    = 3,
  parameter int unsigned POSW   = 12,
  parameter int unsigned CFW    = 1
) (
  input logic            clk,
  input logic            rst,
  input logic [RCW-1:0]  retire_cnt,
  input logic            boundary,
  input logic            qualify,
  input logic [POSW-1:0] pos,
  input logic [CFW-1:0]  conf,
  input logic            mode_en
);
  p_off_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mode_en);

  p_pos_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    32'(pos) < LEN);

  p_surplus_carry_r3: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (32'(pos) == $past(32'(pos) + 32'(retire_cnt) - LEN)));

  p_conf_saturates_r7: assert property (@(posedge clk) disable iff (rst)
    32'(conf) <= CONF_N);

  p_en_needs_conf_r7: assert property (@(posedge clk) disable iff (rst)
    mode_en |-> (32'(conf) == CONF_N));

  p_fail_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (boundary && !qualify) |=> (!mode_en && conf == '0));

  p_en_only_after_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(boundary)) |-> $stable(mode_en));
endmodule

bind slip_mode_ctrl slip_mode_ctrl_chk #(
  .LEN   (INTERVAL_LEN),
  .CONF_N(CONF_N),
  .RCW   ($clog2(RET_W + 1)),
  .POSW  ($clog2(INTERVAL_LEN)),
  .CFW   ($clog2(CONF_N + 1))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .retire_cnt(retire_cnt),
  .boundary  (boundary),
  .qualify   (qualify),
  .pos       (pos),
  .conf      (conf),
  .mode_en   (mode_en)
);

// File: tb/slip_mode_ctrl_bench.sv
`timescale 1ns/1ps
module slip_mode_ctrl_bench;
  import slip_mode_pkg::*;

  localparam int L   = 20;
  localparam int W   = 4;
  localparam int THR = 50;
  localparam int SAT = 63;   // 6-bit cycle accumulator

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] retire_cnt = '0;
  logic [2:0] flag_cnt   = '0;
  logic [3:0] saved_cyc  = '0;
  logic       en_cnt, en_cyc;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // bench model state
  int  m_pos = 0, c_acc = 0, c_conf = 0, y_acc = 0;
  bit  c_en = 1'b0, y_en = 1'b0;

  always #2.5 clk = ~clk;

  slip_mode_ctrl #(
    .INTERVAL_LEN(L), .RET_W(W), .PCT_NUM(30), .PCT_DEN(100),
    .METRIC(MET_COUNT), .CYC_W(4), .CYC_ACC_W(6), .CYC_THRESH(THR), .CONF_N(2)
  ) u_slip_mode_ctrl (
    .clk(clk), .rst(rst), .retire_cnt(retire_cnt), .flag_cnt(flag_cnt),
    .saved_cyc(saved_cyc), .mode_en(en_cnt)
  );

  slip_mode_ctrl #(
    .INTERVAL_LEN(L), .RET_W(W), .PCT_NUM(30), .PCT_DEN(100),
    .METRIC(MET_CYCLES), .CYC_W(4), .CYC_ACC_W(6), .CYC_THRESH(THR), .CONF_N(1)
  ) u_slip_mode_ctrl_cyc (
    .clk(clk), .rst(rst), .retire_cnt(retire_cnt), .flag_cnt(flag_cnt),
    .saved_cyc(saved_cyc), .mode_en(en_cyc)
  );

  task automatic check(bit act, bit exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // One cycle of stimulus; the model predicts the state after the edge.
  task automatic step(int ret, int flg, int cyc, string tag);
    int s, slots, fc, part_old, tot, ytot;
    bit b;
    @(negedge clk);
    retire_cnt = 3'(ret);
    flag_cnt   = 3'(flg);
    saved_cyc  = 4'(cyc);
    s     = m_pos + ret;
    b     = (s >= L);
    slots = b ? (L - m_pos) : ret;
    fc    = (flg > ret) ? ret : flg;
    part_old = (fc > slots) ? slots : fc;
    tot   = c_acc + part_old;
    ytot  = y_acc + cyc;
    if (ytot > SAT) ytot = SAT;
    if (b) begin
      if (tot * 100 > 30 * L) begin
        c_conf = (c_conf == 2) ? 2 : c_conf + 1;
        c_en   = (c_conf == 2);
      end else begin
        c_conf = 0;
        c_en   = 1'b0;
      end
      c_acc = fc - part_old;
      m_pos = s - L;
      y_en  = (ytot > THR);
      y_acc = 0;
    end else begin
      c_acc = tot;
      m_pos = s;
      y_acc = ytot;
    end
    @(posedge clk);
    #1;
    check(en_cnt, c_en, tag, "count-mode enable");
    check(en_cyc, y_en, tag, "cycles-mode enable");
  endtask

  task automatic align(string tag);
    while (m_pos != 0) step(1, 0, 0, tag);
  endtask

  // One interval of single retirements with nflag flagged at the start.
  task automatic one_interval(int nflag, int cyc_each, int cyc_last, string tag);
    for (int i = 0; i < L; i++)
      step(1, (i < nflag) ? 1 : 0, (i == L - 1) ? cyc_last : cyc_each, tag);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(en_cnt, 1'b0, "R1", "count-mode enable in reset");
    check(en_cyc, 1'b0, "R1", "cycles-mode enable in reset");
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, "R1");

    // R2 R3 R4 R9: sweep of group sizes and flag levels, incl. flags > retire
    for (int lv = 0; lv <= 4; lv++)
      for (int t = 0; t < 60; t++) begin
        int r;
        r = (t * 3 + lv) % (W + 1);
        step(r, (lv == 4) ? 7 : ((r < lv) ? r : lv), (t * 7 + lv) % 16, "R2 R3 R4 R9");
      end
    for (int t = 0; t < 80; t++)
      step(t % 5, t % 5, t % 3, "R3 R4 R7 R8 R9");

    // R5: exactly 30% does not qualify, 7 of 20 does; R7 needs two in a row
    align("R5");
    one_interval(7, 0, 0, "R5");
    one_interval(6, 0, 0, "R5");
    one_interval(7, 0, 0, "R7");
    check(en_cnt, 1'b0, "R7", "enable after one qualifying interval");
    one_interval(7, 0, 0, "R7");
    check(en_cnt, 1'b1, "R7", "enable after two qualifying intervals");
    one_interval(20, 0, 0, "R7");
    check(en_cnt, 1'b1, "R7", "enable held at saturated confidence");
    // R8: one failing interval drops it and clears confidence
    one_interval(6, 0, 0, "R8");
    check(en_cnt, 1'b0, "R8", "enable after failing interval");
    one_interval(7, 0, 0, "R8");
    check(en_cnt, 1'b0, "R8", "confidence restarted after failure");

    // R6: cycles mode, 50 does not qualify, 51 does
    one_interval(0, 2, 12, "R6");
    check(en_cyc, 1'b0, "R6", "cycle sum equal to threshold");
    one_interval(0, 2, 13, "R6");
    check(en_cyc, 1'b1, "R6", "cycle sum one above threshold");
    one_interval(0, 0, 0, "R6");
    check(en_cyc, 1'b0, "R6", "zero cycle sum");

    // R10: idle cycles with large savings saturate the accumulator
    for (int i = 0; i < 10; i++) step(0, 0, 15, "R10");
    one_interval(0, 0, 0, "R10");
    check(en_cyc, 1'b1, "R10", "saturated cycle accumulator qualifies");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: finished=0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule